// File: doc/BRIEF.md
# Timer with Edge-Tagged Input Capture

This block is a 16-bit up-counter with a programmable top value and one input-capture channel. Software sets it up through a small register port. It can load the count, set the top value directly or through a buffered copy, pick a clock divider and arm the capture channel. It can also read or acknowledge two event flags. When the count reaches the top value it returns to zero and raises an overflow flag.

An already-synchronized event line feeds an edge detector. When the channel is armed, both rising and falling edges latch the count into a capture register and raise a capture flag. If the top value is below 0x8000, the count cannot use bit 15. In that case bit 15 of the stored value shows which edge fired: 1 for rising, 0 for falling. Software reads the edge direction there and masks the bit off to get the count.

Top module: `edge_capture_timer`

## Requirements
- R1: After reset the count is 0, the top value and the buffered top value are 0xFFFF, the clock select is off, both flags are 0 and the capture value is 0.
- R2: Clock select code 1 advances the count on every clock. Code 0 (and codes 5 to 7) stops it, and the count then holds its value.
- R3: When the count equals the top value on an advancing clock, the next count is 0 and the overflow flag (flag bit 0) is set.
- R4: With capture enabled (control bit 3) and the event action set to capture (control bit 4), every rising edge and every falling edge of the event input copies the count into the capture register and sets the capture flag (flag bit 1).
- R5: If the top value is below 0x8000, the captured bit 15 is 1 for a rising edge and 0 for a falling edge, and bits 14:0 hold the count.
- R6: If the top value is 0x8000 or more, all 16 bits of the count are captured unchanged, whatever the edge direction.
- R7: If either control bit 3 or control bit 4 is clear, edges leave the capture register and the capture flag unchanged.
- R8: The capture register keeps its value through overflows and while the clock is stopped, and changes only on a capture.
- R9: A write to the buffered top value (address 3) reaches the active top value (address 2) at the next overflow. A direct write to address 2 takes effect at once.
- R10: Writing 1 to a bit of the flag register (address 4) clears that flag. A flag that is set in the same cycle stays set.
- R11: Clock select codes 2, 3 and 4 advance the count once every 2, 4 and 8 clocks. The first advance comes 2, 4 or 8 clocks after the code is written from the stopped state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address: 0 control, 1 count, 2 top, 3 buffered top, 4 flags |
| wr_data | input | 16 | Write data; control uses [2:0] clock select, [3] capture enable, [4] capture action |
| rd_addr | input | 3 | Read address; 5 returns the capture register |
| rd_data | output | 16 | Combinational read data |
| evt_in | input | 1 | Synchronized event line |
| ovf_flag | output | 1 | Overflow flag |
| cap_flag | output | 1 | Capture flag |
| cap_value | output | 16 | Capture register |

## Verification
Captures are taken with the counter stopped on chosen counts, so every captured word can be predicted exactly. Rising and falling edges are sent with a large top value, then with a small one. Comparing the two runs separates the untagged capture from the tagged one. A count with bit 14 set shows that the tag replaces only bit 15. Edges sent while one of the two arming bits is clear show whether each bit gates the capture. A clear sent in the same cycle as a new capture shows which one wins. Running phases tell apart divide-by-one, divide-by-two and divide-by-four counting. They also show the wrap at an exact top value and a buffered top value taking effect only after the wrap.

// File: rtl/ect_pkg.sv
package ect_pkg;

    localparam int CNT_W   = 16;
    localparam int PRESC_W = 3;
    localparam int ADDR_W  = 3;

    typedef logic [CNT_W-1:0] cnt_t;

    typedef enum logic [2:0] {
        CS_OFF  = 3'd0,
        CS_DIV1 = 3'd1,
        CS_DIV2 = 3'd2,
        CS_DIV4 = 3'd3,
        CS_DIV8 = 3'd4
    } clksel_e;

    typedef enum logic [ADDR_W-1:0] {
        A_CTRL   = 3'd0,
        A_COUNT  = 3'd1,
        A_TOP    = 3'd2,
        A_TOPBUF = 3'd3,
        A_FLAGS  = 3'd4,
        A_CAPT   = 3'd5
    } addr_e;

    typedef struct packed {
        logic    act_cap;
        logic    cap_en;
        clksel_e clksel;
    } ctrl_t;

    // Low prescale bits that must all be ones for a divided tick.
    function automatic logic [PRESC_W-1:0] presc_mask(input clksel_e s);
        case (s)
            CS_DIV2: return PRESC_W'(1);
            CS_DIV4: return PRESC_W'(3);
            CS_DIV8: return PRESC_W'(7);
            default: return '0;
        endcase
    endfunction

    // Build the stored capture word; small top values free the MSB for the edge tag.
    function automatic cnt_t tag_capture(input cnt_t cnt, input cnt_t top, input logic rising);
        if (!top[CNT_W-1]) return {rising, cnt[CNT_W-2:0]};
        return cnt;
    endfunction

endpackage

// File: rtl/ect_prescaler.sv
module ect_prescaler
    import ect_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  clksel_e sel,
    output logic    tick
);
    logic [PRESC_W-1:0] pcnt_q;
    logic [PRESC_W-1:0] mask;
    logic               running;

    always_comb begin
        mask    = presc_mask(sel);
        running = (sel == CS_DIV1) || (sel == CS_DIV2) ||
                  (sel == CS_DIV4) || (sel == CS_DIV8);
        tick    = running && ((pcnt_q & mask) == mask);
    end

    always_ff @(posedge clk) begin
        if (rst || !running) pcnt_q <= '0;
        else                 pcnt_q <= pcnt_q + 1'b1;
    end

    p_div2_r11: assert property (@(posedge clk) disable iff (rst)
        (tick && sel == CS_DIV2) |=> (!tick || sel != CS_DIV2));

endmodule

// File: rtl/ect_edge_detect.sv
module ect_edge_detect (
    input  logic clk,
    input  logic rst,
    input  logic evt_in,
    output logic rise,
    output logic fall
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= evt_in;
    end

    always_comb begin
        rise = evt_in && !prev_q;
        fall = !evt_in && prev_q;
    end

endmodule

// File: rtl/ect_capture.sv
module ect_capture
    import ect_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic rise,
    input  logic fall,
    input  logic armed,
    input  cnt_t cnt,
    input  cnt_t top,
    output cnt_t cap_q,
    output logic cap_go
);
    always_comb cap_go = armed && (rise || fall);

    always_ff @(posedge clk) begin
        if (rst)         cap_q <= '0;
        else if (cap_go) cap_q <= tag_capture(cnt, top, rise);
    end

    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !cap_go |=> $stable(cap_q));
    p_rise_tag_r5: assert property (@(posedge clk) disable iff (rst)
        (cap_go && rise && !top[CNT_W-1]) |=> cap_q[CNT_W-1]);
    p_fall_tag_r5: assert property (@(posedge clk) disable iff (rst)
        (cap_go && fall && !top[CNT_W-1]) |=> !cap_q[CNT_W-1]);
    p_full_r6: assert property (@(posedge clk) disable iff (rst)
        (cap_go && top[CNT_W-1]) |=> cap_q == $past(cnt));

endmodule

// File: rtl/edge_capture_timer.sv
module edge_capture_timer
    import ect_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [2:0]  wr_addr,
    input  logic [15:0] wr_data,
    input  logic [2:0]  rd_addr,
    output logic [15:0] rd_data,
    input  logic        evt_in,
    output logic        ovf_flag,
    output logic        cap_flag,
    output logic [15:0] cap_value
);
    ctrl_t ctrl_q;
    cnt_t  cnt_q, top_q, topbuf_q, capv;
    logic  buf_pend_q, ovf_q, capf_q;
    logic  tick, wrap, rise, fall, cap_go;
    logic  wr_ctrl, wr_cnt, wr_top, wr_buf, wr_flags;

    always_comb begin
        wr_ctrl  = wr_en && (wr_addr == A_CTRL);
        wr_cnt   = wr_en && (wr_addr == A_COUNT);
        wr_top   = wr_en && (wr_addr == A_TOP);
        wr_buf   = wr_en && (wr_addr == A_TOPBUF);
        wr_flags = wr_en && (wr_addr == A_FLAGS);
        wrap     = tick && (cnt_q == top_q);
    end

    ect_prescaler u_presc (
        .clk (clk), .rst (rst), .sel (ctrl_q.clksel), .tick (tick)
    );

    ect_edge_detect u_edge (
        .clk (clk), .rst (rst), .evt_in (evt_in), .rise (rise), .fall (fall)
    );

    ect_capture u_cap (
        .clk (clk), .rst (rst), .rise (rise), .fall (fall),
        .armed (ctrl_q.cap_en && ctrl_q.act_cap),
        .cnt (cnt_q), .top (top_q), .cap_q (capv), .cap_go (cap_go)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q     <= '{act_cap: 1'b0, cap_en: 1'b0, clksel: CS_OFF};
            cnt_q      <= '0;
            top_q      <= '1;
            topbuf_q   <= '1;
            buf_pend_q <= 1'b0;
            ovf_q      <= 1'b0;
            capf_q     <= 1'b0;
        end else begin
            if (wr_ctrl)
                ctrl_q <= '{act_cap: wr_data[4], cap_en: wr_data[3],
                            clksel: clksel_e'(wr_data[2:0])};

            if (wr_cnt)    cnt_q <= wr_data;
            else if (tick) cnt_q <= wrap ? '0 : cnt_q + 1'b1;

            if (wr_top)                  top_q <= wr_data;
            else if (wrap && buf_pend_q) top_q <= topbuf_q;

            if (wr_buf) begin
                topbuf_q   <= wr_data;
                buf_pend_q <= 1'b1;
            end else if (wrap) begin
                buf_pend_q <= 1'b0;
            end

            ovf_q  <= wrap   || (ovf_q  && !(wr_flags && wr_data[0]));
            capf_q <= cap_go || (capf_q && !(wr_flags && wr_data[1]));
        end
    end

    always_comb begin
        case (rd_addr)
            A_CTRL:   rd_data = {11'b0, ctrl_q};
            A_COUNT:  rd_data = cnt_q;
            A_TOP:    rd_data = top_q;
            A_TOPBUF: rd_data = topbuf_q;
            A_FLAGS:  rd_data = {14'b0, capf_q, ovf_q};
            A_CAPT:   rd_data = capv;
            default:  rd_data = '0;
        endcase
        ovf_flag  = ovf_q;
        cap_flag  = capf_q;
        cap_value = capv;
    end

    p_wrap_r3: assert property (@(posedge clk) disable iff (rst)
        (tick && cnt_q == top_q && !wr_cnt) |=> (cnt_q == '0 && ovf_q));
    p_off_freeze_r2: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.clksel == CS_OFF && !wr_cnt) |=> $stable(cnt_q));
    p_buf_load_r9: assert property (@(posedge clk) disable iff (rst)
        (wrap && buf_pend_q && !wr_top && !wr_buf) |=> top_q == $past(topbuf_q));
    p_set_wins_r10: assert property (@(posedge clk) disable iff (rst)
        cap_go |=> capf_q);
    p_w1c_r10: assert property (@(posedge clk) disable iff (rst)
        (wr_flags && wr_data[0] && !wrap) |=> !ovf_q);

endmodule

// File: tb/edge_capture_timer_tb.sv
module edge_capture_timer_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic        evt_in = 1'b0;
    logic        ovf_flag, cap_flag;
    logic [15:0] cap_value;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [15:0] exp_q[$];
    string       tag_q[$];
    logic        seen_q = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    edge_capture_timer u_dut (
        .clk (clk), .rst (rst), .wr_en (wr_en), .wr_addr (wr_addr),
        .wr_data (wr_data), .rd_addr (rd_addr), .rd_data (rd_data),
        .evt_in (evt_in), .ovf_flag (ovf_flag), .cap_flag (cap_flag),
        .cap_value (cap_value)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%04h expected=0x%04h", tag, act, exp);
        end
    endtask

    // Called at a falling edge; the write lands on the next rising edge.
    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    // Driver: predicts the captured word and changes the event line.
    task automatic drive_edge(input logic level, input logic [15:0] exp, input string tag);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        evt_in = level;
        @(negedge clk);
    endtask

    // Monitor: each new capture flag pops one prediction.
    always @(negedge clk) begin
        if (!rst) begin
            if (cap_flag && !seen_q) begin
                if (exp_q.size() == 0) begin
                    checks++; failures++;
                    $display("FAIL R4 unexpected capture actual=0x%04h expected=none", cap_value);
                end else begin
                    check(tag_q.pop_front(), cap_value, exp_q.pop_front());
                end
            end
            seen_q <= cap_flag;
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(3'd1, v); check("R1 count", v, 16'h0000);
        rd(3'd2, v); check("R1 top", v, 16'hFFFF);
        rd(3'd3, v); check("R1 topbuf", v, 16'hFFFF);
        rd(3'd0, v); check("R1 ctrl", v, 16'h0000);
        check("R1 flags", {14'b0, cap_flag, ovf_flag}, 16'h0000);
        check("R1 capture", cap_value, 16'h0000);

        // R2 divide by one, then stop
        wr(3'd0, 16'h0019);
        idle(5);
        rd(3'd1, v); check("R2 div1 count", v, 16'd5);
        wr(3'd0, 16'h0018);
        idle(3);
        rd(3'd1, v); check("R2 frozen count", v, 16'd6);

        // R4/R6 large top value: full count, both edges
        wr(3'd1, 16'h1234);
        drive_edge(1'b1, 16'h1234, "R6 rise full");
        wr(3'd4, 16'h0003);
        drive_edge(1'b0, 16'h1234, "R4 fall capture");
        wr(3'd4, 16'h0003);

        // R5 small top value: edge tag in bit 15
        wr(3'd2, 16'h0100);
        wr(3'd1, 16'h0042);
        drive_edge(1'b1, 16'h8042, "R5 rise tag");
        wr(3'd4, 16'h0003);
        drive_edge(1'b0, 16'h0042, "R5 fall tag");
        wr(3'd4, 16'h0003);
        wr(3'd1, 16'h7ABC);
        drive_edge(1'b1, 16'hFABC, "R5 rise bit14 kept");
        wr(3'd4, 16'h0003);

        // R7 either arming bit clear blocks capture
        wr(3'd0, 16'h0010);
        wr(3'd1, 16'h0555);
        evt_in = 1'b0; idle(2);
        check("R7 action only value", cap_value, 16'hFABC);
        check("R7 action only flag", {15'b0, cap_flag}, 16'h0000);
        wr(3'd0, 16'h0008);
        evt_in = 1'b1; idle(2);
        check("R7 enable only value", cap_value, 16'hFABC);
        check("R7 enable only flag", {15'b0, cap_flag}, 16'h0000);

        // R10 set beats clear in the same cycle
        wr(3'd0, 16'h0018);
        exp_q.push_back(16'h0555); tag_q.push_back("R10 capture during clear");
        evt_in = 1'b0;
        wr(3'd4, 16'h0002);
        check("R10 set wins", {15'b0, cap_flag}, 16'h0001);
        wr(3'd4, 16'h0002);
        check("R10 clear", {15'b0, cap_flag}, 16'h0000);

        // R8 capture held across overflows and stop
        wr(3'd2, 16'h0004);
        wr(3'd1, 16'h0000);
        wr(3'd0, 16'h0019);
        idle(10);
        wr(3'd0, 16'h0018);
        check("R8 held", cap_value, 16'h0555);
        check("R8 overflow seen", {15'b0, ovf_flag}, 16'h0001);

        // R3 exact wrap point, R10 overflow clear
        wr(3'd4, 16'h0003);
        wr(3'd2, 16'h0005);
        wr(3'd1, 16'h0002);
        wr(3'd0, 16'h0019);
        idle(3);
        rd(3'd1, v); check("R3 at top", v, 16'd5);
        check("R3 no flag yet", {15'b0, ovf_flag}, 16'h0000);
        idle(1);
        rd(3'd1, v); check("R3 wrapped", v, 16'd0);
        check("R3 flag", {15'b0, ovf_flag}, 16'h0001);
        wr(3'd4, 16'h0001);
        check("R10 ovf cleared", {15'b0, ovf_flag}, 16'h0000);
        wr(3'd0, 16'h0018);

        // R9 buffered top applies at the wrap, direct write at once
        wr(3'd1, 16'h0000);
        wr(3'd2, 16'h0003);
        wr(3'd3, 16'h0007);
        wr(3'd4, 16'h0003);
        wr(3'd0, 16'h0019);
        idle(3);
        rd(3'd2, v); check("R9 top before wrap", v, 16'h0003);
        idle(1);
        rd(3'd1, v); check("R9 wrapped", v, 16'd0);
        rd(3'd2, v); check("R9 top after wrap", v, 16'h0007);
        idle(7);
        rd(3'd1, v); check("R9 new top used", v, 16'd7);
        wr(3'd2, 16'h0002);
        rd(3'd2, v); check("R9 direct write", v, 16'h0002);
        wr(3'd0, 16'h0018);

        // R11 divided clocks
        wr(3'd2, 16'hFFFF);
        wr(3'd1, 16'h0000);
        wr(3'd0, 16'h001B);
        idle(8);
        rd(3'd1, v); check("R11 div4", v, 16'd2);
        wr(3'd0, 16'h0018);
        wr(3'd1, 16'h0000);
        wr(3'd0, 16'h001A);
        idle(6);
        rd(3'd1, v); check("R11 div2", v, 16'd3);
        wr(3'd0, 16'h0018);

        idle(2);
        check("R4 all captures seen", 16'(exp_q.size()), 16'd0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule